// File: doc/BRIEF.md
# Watchdog Timer Reset Generator

This block watches over a processor by counting clock cycles without pause. Firmware keeps it quiet by writing to a fixed service address on a small register bus. Any write to that address restarts the count, and the value written does not matter. If firmware stops servicing it, the count reaches the timeout. The block then drives a reset request for a fixed number of cycles, and after that the count starts again from zero.

Each expiry sets a sticky cause flag in a status register, so reset code can tell that the watchdog caused the restart. The flag survives the reset pulse. Only a firmware write with the flag bit at zero clears it, or the external hard reset.

The block also holds the oscillator-enable setting in a configuration register. An expiry clears the stored bit. The oscillator-enable output keeps its old value until the next suspend entry, and only then takes the stored value. The timeout and the pulse length are parameters in clock cycles.

Top module: `wdt_reset_gen`

## Requirements
- R1: A write to the service address 0x26 clears the counter whatever the write data is. With no further service, the reset request rises exactly TIMEOUT clock edges after the edge that sampled the write.
- R2: While the counter is not cleared, the reset request stays low until TIMEOUT edges after the last clear, never earlier, and rises on that edge.
- R3: Once raised, the reset request stays high for exactly PULSE cycles and then falls.
- R4: On each expiry, bit 6 of the status register (address 0x30, read value 0x40) becomes 1, in the same cycle the reset request rises.
- R5: A write to the status register with bit 6 at 0 clears the cause flag. A write with bit 6 at 1 leaves it set. Other written bits are ignored and read as 0.
- R6: An expiry clears the stored oscillator-enable bit (bit 0 of the configuration register at 0x31), and the oscillator-enable output keeps its value.
- R7: A write to the configuration register sets the stored bit and the output from written bit 0 on the next cycle. A one-cycle suspend-entry pulse copies the stored bit to the output.
- R8: A read of 0x26 (or of any unmapped address) returns 0, and continuous reads of 0x26 do not change the expiry time.
- R9: While the reset request is high the counter is held at zero. The next expiry follows TIMEOUT edges after the edge on which the request falls.
- R10: The active-low hard reset clears the reset request, the cause flag, the stored oscillator bit and the oscillator-enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| suspend_enter | input | 1 | One-cycle pulse at suspend entry |
| wdt_rst_req | output | 1 | Watchdog reset request pulse |
| osc_en | output | 1 | Effective oscillator-enable |

## Verification
Every result has a fixed latency. A write takes effect on the edge that samples it, and read data follows the address in the same cycle. The reset request rises TIMEOUT edges after the clearing edge and falls PULSE edges after that. The cause flag appears together with the rise. The suspend copy shows up one edge after the pulse.

The driver computes the exact cycle of each expected value from the cycle of its own stimulus and queues it. The monitor pops each item at the falling edge of that cycle. It checks both sides of each boundary, one cycle before the expiry or fall and the cycle of it, so a result that comes one cycle early or late is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Bit positions firmware decodes
    localparam int CAUSE_BIT = 6;
    localparam int OSC_BIT   = 0;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_STAT,
        RSEL_CFG
    } rd_sel_e;

    typedef struct packed {
        logic svc;
        logic stat;
        logic cfg;
    } wr_dec_t;

endpackage

// File: rtl/wdt_bus_dec.sv
module wdt_bus_dec
    import wdt_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] SVC_ADDR  = AW'(8'h26),
    parameter logic [AW-1:0] STAT_ADDR = AW'(8'h30),
    parameter logic [AW-1:0] CFG_ADDR  = AW'(8'h31)
) (
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    output wr_dec_t       wr_o,
    output rd_sel_e       rsel_o
);

    wr_dec_t wr_d;
    rd_sel_e rsel_d;

    always_comb begin
        wr_d.svc  = wr_i && (addr_i == SVC_ADDR);
        wr_d.stat = wr_i && (addr_i == STAT_ADDR);
        wr_d.cfg  = wr_i && (addr_i == CFG_ADDR);
        if (addr_i == STAT_ADDR)     rsel_d = RSEL_STAT;
        else if (addr_i == CFG_ADDR) rsel_d = RSEL_CFG;
        else                         rsel_d = RSEL_NONE;
    end

    assign wr_o   = wr_d;
    assign rsel_o = rsel_d;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int TIMEOUT = 60600,
    localparam int CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          hold_i,
    output logic          expire_o,
    output logic [CW-1:0] cnt_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic at_top;

    always_comb begin
        st_d     = st_q;
        at_top   = (st_q.cnt == CW'(TIMEOUT - 1));
        expire_o = 1'b0;
        if (hold_i || clear_i) begin
            st_d.cnt = '0;
        end else if (at_top) begin
            st_d.cnt = '0;
            expire_o = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> (st_q.cnt == '0));

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(TIMEOUT - 1));

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE = 18000,
    localparam int PW = $clog2(PULSE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    output logic active_o
);

    typedef struct packed {
        logic          active;
        logic [PW-1:0] left;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.left == '0) st_d.active = 1'b0;
            else                 st_d.left   = st_q.left - 1'b1;
        end else if (expire_i) begin
            st_d.active = 1'b1;
            st_d.left   = PW'(PULSE - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;

    assert_pulse_from_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(expire_i));

    assert_left_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= PW'(PULSE - 1));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_dec_t       wr_i,
    input  rd_sel_e       rsel_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          expire_i,
    input  logic          suspend_i,
    output logic [DW-1:0] rdata_o,
    output logic          osc_en_o
);

    typedef struct packed {
        logic cause;
        logic osc_cfg;
        logic osc_act;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i.stat && !wdata_i[CAUSE_BIT]) st_d.cause = 1'b0;
        if (expire_i)                         st_d.cause = 1'b1;

        if (wr_i.cfg) begin
            st_d.osc_cfg = wdata_i[OSC_BIT];
            st_d.osc_act = wdata_i[OSC_BIT];
        end
        if (expire_i) st_d.osc_cfg = 1'b0;
        if (suspend_i && !wr_i.cfg) st_d.osc_act = st_q.osc_cfg;

        rdata_o = '0;
        case (rsel_i)
            RSEL_STAT: rdata_o[CAUSE_BIT] = st_q.cause;
            RSEL_CFG:  rdata_o[OSC_BIT]   = st_q.osc_cfg;
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign osc_en_o = st_q.osc_act;

    assert_cause_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(expire_i) |-> st_q.cause);

    assert_cause_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.cause) |-> $past(wr_i.stat && !wdata_i[CAUSE_BIT]));

    assert_osc_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.osc_act) |-> $past(suspend_i || wr_i.cfg));

    assert_cfg_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(expire_i) |-> !st_q.osc_cfg);

endmodule

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen
    import wdt_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int TIMEOUT = 60600,
    parameter int PULSE   = 18000,
    parameter logic [AW-1:0] SVC_ADDR  = AW'(8'h26),
    parameter logic [AW-1:0] STAT_ADDR = AW'(8'h30),
    parameter logic [AW-1:0] CFG_ADDR  = AW'(8'h31),
    localparam int CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          suspend_enter,
    output logic          wdt_rst_req,
    output logic          osc_en
);

    wr_dec_t       wr_dec;
    rd_sel_e       rsel;
    logic          expire;
    logic          pulse_on;
    logic [CW-1:0] cnt;

    wdt_bus_dec #(
        .AW(AW), .SVC_ADDR(SVC_ADDR), .STAT_ADDR(STAT_ADDR), .CFG_ADDR(CFG_ADDR)
    ) u_dec (
        .addr_i(bus_addr), .wr_i(bus_wr), .wr_o(wr_dec), .rsel_o(rsel)
    );

    wdt_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear_i(wr_dec.svc), .hold_i(pulse_on),
        .expire_o(expire), .cnt_o(cnt)
    );

    wdt_pulse #(.PULSE(PULSE)) u_pulse (
        .clk(clk), .rst_n(rst_n), .expire_i(expire), .active_o(pulse_on)
    );

    wdt_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_dec), .rsel_i(rsel),
        .wdata_i(bus_wdata), .expire_i(expire), .suspend_i(suspend_enter),
        .rdata_o(bus_rdata), .osc_en_o(osc_en)
    );

    assign wdt_rst_req = pulse_on;

    assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> (cnt == '0));

    assert_rise_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_req) |-> $past(cnt == CW'(TIMEOUT - 1)));

endmodule

// File: tb/wdt_reset_gen_tb.sv
module wdt_reset_gen_tb;

    localparam int T = 20;
    localparam int P = 5;
    localparam logic [7:0] SVC  = 8'h26;
    localparam logic [7:0] STAT = 8'h30;
    localparam logic [7:0] CFG  = 8'h31;
    localparam int K_RST = 0;
    localparam int K_RD  = 1;
    localparam int K_OSC = 2;

    typedef struct {
        int         at;
        int         kind;
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       suspend_enter = 1'b0;
    logic       wdt_rst_req;
    logic       osc_en;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_reset_gen #(.TIMEOUT(T), .PULSE(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .suspend_enter(suspend_enter), .wdt_rst_req(wdt_rst_req), .osc_en(osc_en)
    );

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic void expect_at(input int at, input int kind,
                                      input logic [7:0] val, input string tag);
        exp_t e;
        e.at = at; e.kind = kind; e.val = val; e.tag = tag;
        sb.push_back(e);
    endfunction

    task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    // Monitor: pops expected items due in the current cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            logic [7:0] act;
            e = sb.pop_front();
            case (e.kind)
                K_RST:   act = {7'd0, wdt_rst_req};
                K_OSC:   act = {7'd0, osc_en};
                default: act = bus_rdata;
            endcase
            n_tests++;
            if (e.at != cyc || act !== e.val) begin
                n_fail++;
                $display("FAIL %s kind=%0d cycle=%0d due=%0d actual=%0h expected=%0h",
                         e.tag, e.kind, cyc, e.at, act, e.val);
            end
        end
    end

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        int tclr;
        int tfall;
        logic [7:0] pat [3];
        pat[0] = 8'hFF; pat[1] = 8'hA5; pat[2] = 8'h5A;

        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10 reset state
        expect_at(cyc, K_RST, 8'h00, "R10");
        expect_at(cyc, K_OSC, 8'h00, "R10");
        bus_addr = STAT; expect_at(cyc, K_RD, 8'h00, "R10");
        tick(1);
        bus_addr = SVC;  expect_at(cyc, K_RD, 8'h00, "R8");
        tick(1);
        bus_addr = CFG;  expect_at(cyc, K_RD, 8'h00, "R10");

        bwrite(SVC, 8'h00); tclr = cyc;
        // R7 config write reaches register and output
        bwrite(CFG, 8'h01);
        expect_at(cyc, K_OSC, 8'h01, "R7");
        expect_at(cyc, K_RD, 8'h01, "R7");

        // R1 service with varied data keeps reset away
        for (int i = 0; i < 3; i++) begin
            tick(14);
            expect_at(cyc, K_RST, 8'h00, "R1");
            bwrite(SVC, pat[i]); tclr = cyc;
        end

        // R2 / R8 expiry timing while reading the service address
        bus_addr = SVC;
        tick(T - 1);
        expect_at(cyc, K_RST, 8'h00, "R2");
        expect_at(cyc, K_RD, 8'h00, "R8");
        tick(1);
        expect_at(cyc, K_RST, 8'h01, "R2");
        bus_addr = CFG;
        expect_at(cyc, K_RD, 8'h00, "R6");
        expect_at(cyc, K_OSC, 8'h01, "R6");
        tick(P - 1);
        expect_at(cyc, K_RST, 8'h01, "R3");
        tick(1);
        expect_at(cyc, K_RST, 8'h00, "R3");
        tfall = cyc;
        bus_addr = STAT;
        expect_at(cyc, K_RD, 8'h40, "R4");

        // R5 cause flag write behaviour
        bwrite(STAT, 8'h40);
        expect_at(cyc, K_RD, 8'h40, "R5");
        bwrite(STAT, 8'hBF);
        expect_at(cyc, K_RD, 8'h00, "R5");

        // R7 suspend entry copies stored bit to output
        suspend_enter = 1'b1;
        tick(1);
        suspend_enter = 1'b0;
        expect_at(cyc, K_OSC, 8'h00, "R7");

        // R9 next expiry counted from end of pulse
        tick(tfall + T - 1 - cyc);
        expect_at(cyc, K_RST, 8'h00, "R9");
        tick(1);
        expect_at(cyc, K_RST, 8'h01, "R9");
        expect_at(cyc, K_RD, 8'h40, "R4");

        // R10 hard reset during pulse
        tick(2);
        rst_n = 1'b0;
        tick(1);
        expect_at(cyc, K_RST, 8'h00, "R10");
        expect_at(cyc, K_RD, 8'h00, "R10");
        rst_n = 1'b1;
        tick(3);

        while (sb.size() > 0) tick(1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule